// File: doc/BRIEF.md
# Dual Clock Mode Controller

This block manages which oscillator drives the processor core and which drives the interval timer in a microcontroller that has both a fast and a slow oscillator. It runs in one of three modes. In Fast mode both the core and the timer run from the fast oscillator. In Slow mode both run from the slow oscillator. In Dual mode the core runs from the fast oscillator while the timer runs from the slow one. The oscillators and the glitch-free clock multiplexers sit outside the block, which drives only their enables and selects.

Four control levels come from a register: `slow_on_i` and `fast_on_i` request the two oscillators, `split_en_i` asks for Dual mode, and `core_slow_i` asks for the core to run slowly. Only a change in `split_en_i` or `core_slow_i` requests a mode change, and a change takes effect in the same clock edge that samples it. A request is refused if the oscillator it would select is not both switched on and reported stable. A refused request is dropped. It is not retried. The stable flags come from the analog oscillators, so each one passes through a synchronizer before it is used.

Top module: `clk_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with all control inputs low, the outputs read as follows: mode 00 (Fast), `fast_en_o`=1, `slow_en_o`=0, `core_sel_o`=0, `timer_sel_o`=0.
- R2: In Fast mode, a 0-to-1 change of `split_en_i` moves the block to Dual mode at the edge that samples it, provided the slow oscillator is ready. Ready means `slow_on_i`=1 and the synchronized slow stable flag is 1.
- R3: In Slow mode, a 1-to-0 change of `core_slow_i` moves the block to Dual mode, provided the fast oscillator is ready. Ready means `fast_on_i`=1 and the synchronized fast stable flag is 1.
- R4: In Dual mode `core_sel_o`=0 (fast) and `timer_sel_o`=1 (slow). In Fast mode both selects are 0. In Slow mode both selects are 1.
- R5: A request that would select an oscillator that is not ready is ignored. The mode stays as it was, and holding the control level afterwards does not complete the change later.
- R6: `mode_o` encodes the mode as 00 Fast, 01 Slow, 10 Dual. The code 11 never appears.
- R7: A stable flag is seen through two synchronizer flops. A request sampled at the second rising edge after the raw flag rises is refused. A request sampled at the third edge is accepted.
- R8: `slow_en_o` is 1 whenever the mode is Slow or Dual, or when `slow_on_i`=1. `fast_en_o` is 1 whenever the mode is Fast or Dual, or when `fast_on_i`=1.
- R9: The other transitions are as follows. From Fast, a rise of `core_slow_i` leads to Slow if the slow oscillator is ready. From Dual, a fall of `split_en_i` leads to Fast. From Dual, a rise of `core_slow_i` leads to Slow if the slow oscillator is ready.
- R10: In Fast mode, if `split_en_i` and `core_slow_i` rise at the same edge and the slow oscillator is ready, the block goes to Dual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, forces Fast mode |
| slow_on_i | input | 1 | Software request to run the slow oscillator |
| fast_on_i | input | 1 | Software request to run the fast oscillator |
| split_en_i | input | 1 | Dual mode request (acts on changes) |
| core_slow_i | input | 1 | Core slow-clock request (acts on changes) |
| slow_stable_i | input | 1 | Asynchronous slow oscillator stable flag |
| fast_stable_i | input | 1 | Asynchronous fast oscillator stable flag |
| slow_en_o | output | 1 | Slow oscillator enable |
| fast_en_o | output | 1 | Fast oscillator enable |
| core_sel_o | output | 1 | Core clock select, 1 = slow |
| timer_sel_o | output | 1 | Interval timer clock select, 1 = slow |
| mode_o | output | 2 | Current mode code |

## Verification
The assertions assume two things about the inputs. The control levels change only between clock edges. The raw stable flags may change at any time, because the logic only ever sees their synchronized copies. The bench drives every input just after a falling edge and reads every output just before the next falling edge. Every transition therefore lands on a known rising edge, including the edge-exact acceptance of a request once a flag has been synchronized. Apart from the reset assertion, each assertion is disabled during reset, so the power-up values of the synchronizer flops never count.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FAST = 2'b00,
        MODE_SLOW = 2'b01,
        MODE_DUAL = 2'b10
    } clk_mode_e;

    typedef struct packed {
        clk_mode_e mode;
    } cmc_state_t;

    localparam cmc_state_t CMC_RESET = '{mode: MODE_FAST};

endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cmc_edge.sv
module cmc_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
        fall_o = ~level_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_on_i,
    input  logic       fast_on_i,
    input  logic       split_en_i,
    input  logic       core_slow_i,
    input  logic       slow_stable_i,
    input  logic       fast_stable_i,
    output logic       slow_en_o,
    output logic       fast_en_o,
    output logic       core_sel_o,
    output logic       timer_sel_o,
    output logic [1:0] mode_o
);

    localparam int NUM_OSC  = 2;
    localparam int NUM_CTRL = 2;
    localparam int IDX_SLOW = 0;
    localparam int IDX_FAST = 1;
    localparam int IDX_SPLIT = 0;
    localparam int IDX_CORE  = 1;

    logic [NUM_OSC-1:0]  stable_sync;
    logic [NUM_CTRL-1:0] ctrl_rise, ctrl_fall;
    logic                slow_ok, fast_ok;
    cmc_state_t          st_d, st_q;

    cmc_sync #(.WIDTH(NUM_OSC), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fast_stable_i, slow_stable_i}),
        .sync_o  (stable_sync)
    );

    cmc_edge #(.WIDTH(NUM_CTRL)) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({core_slow_i, split_en_i}),
        .rise_o  (ctrl_rise),
        .fall_o  (ctrl_fall)
    );

    always_comb begin
        slow_ok = slow_on_i & stable_sync[IDX_SLOW];
        fast_ok = fast_on_i & stable_sync[IDX_FAST];
        st_d    = st_q;
        unique case (st_q.mode)
            MODE_FAST: begin
                if (ctrl_rise[IDX_SPLIT] && slow_ok)      st_d.mode = MODE_DUAL;
                else if (ctrl_rise[IDX_CORE] && slow_ok)  st_d.mode = MODE_SLOW;
            end
            MODE_SLOW: begin
                if (ctrl_fall[IDX_CORE] && fast_ok)       st_d.mode = MODE_DUAL;
            end
            MODE_DUAL: begin
                if (ctrl_fall[IDX_SPLIT])                 st_d.mode = MODE_FAST;
                else if (ctrl_rise[IDX_CORE] && slow_ok)  st_d.mode = MODE_SLOW;
            end
            default:                                      st_d.mode = MODE_FAST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CMC_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        mode_o      = st_q.mode;
        core_sel_o  = (st_q.mode == MODE_SLOW);
        timer_sel_o = (st_q.mode != MODE_FAST);
        slow_en_o   = slow_on_i | (st_q.mode != MODE_FAST);
        fast_en_o   = fast_on_i | (st_q.mode != MODE_SLOW);
    end

    // R1: the first sampled edge after reset release shows Fast mode
    assert_reset_fast_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mode_o == MODE_FAST));

    // R6: no code outside the three modes
    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    // R2/R5: entering Dual from Fast requires the slow oscillator to be ready
    assert_dual_needs_slow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == MODE_FAST && mode_o == MODE_DUAL) |-> $past(slow_ok));

    // R3/R5: entering Dual from Slow requires the fast oscillator to be ready
    assert_dual_needs_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == MODE_SLOW && mode_o == MODE_DUAL) |-> $past(fast_ok));

    // R8: any oscillator that feeds a selected clock is enabled
    assert_slow_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_sel_o || timer_sel_o) |-> slow_en_o);
    assert_fast_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !core_sel_o |-> fast_en_o);

    // R4: the core never runs slower than the timer
    assert_core_vs_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_sel_o |-> timer_sel_o);

endmodule

// File: tb/test_clk_mode_ctrl.sv
`timescale 1ns/100ps
module test_clk_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_on = 1'b0, fast_on = 1'b0, split_en = 1'b0, core_slow = 1'b0;
    logic       slow_st = 1'b0, fast_st = 1'b0;
    logic       slow_en, fast_en, core_sel, timer_sel;
    logic [1:0] mode;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    clk_mode_ctrl i_clk_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .slow_on_i     (slow_on),
        .fast_on_i     (fast_on),
        .split_en_i    (split_en),
        .core_slow_i   (core_slow),
        .slow_stable_i (slow_st),
        .fast_stable_i (fast_st),
        .slow_en_o     (slow_en),
        .fast_en_o     (fast_en),
        .core_sel_o    (core_sel),
        .timer_sel_o   (timer_sel),
        .mode_o        (mode)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_outs(input string req, input logic [1:0] m);
        chk(req, mode, m);
        chk(req, {1'b0, core_sel},  {1'b0, m == 2'b01});
        chk(req, {1'b0, timer_sel}, {1'b0, m != 2'b00});
        chk(req, {1'b0, slow_en},   {1'b0, slow_on | (m != 2'b00)});
        chk(req, {1'b0, fast_en},   {1'b0, fast_on | (m != 2'b01)});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        slow_on = 0; fast_on = 0; split_en = 0; core_slow = 0;
        step();
        chk_outs("R1 in reset", 2'b00);
        step();
        rst_n = 1'b1;
        step();
        chk_outs("R1 after reset", 2'b00);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R5: Dual request with the slow oscillator on but not stable
        slow_on = 1; step();
        chk("R8 slow_en from request", {1'b0, slow_en}, 2'b01);
        split_en = 1; step();
        chk_outs("R5 split refused", 2'b00);
        step();
        chk("R5 held level does not retry", mode, 2'b00);
        split_en = 0; step();

        // R7: the request at the second edge after the flag is refused
        slow_st = 1; step();
        split_en = 1; step();
        chk("R7 second edge refused", mode, 2'b00);
        split_en = 0; step();
        split_en = 1; step();
        chk_outs("R2 Fast to Dual", 2'b10);
        chk("R4 Dual core fast", {1'b0, core_sel}, 2'b00);
        chk("R4 Dual timer slow", {1'b0, timer_sel}, 2'b01);

        // R9: Dual to Fast, then Fast to Slow
        split_en = 0; step();
        chk_outs("R9 Dual to Fast", 2'b00);
        core_slow = 1; step();
        chk_outs("R9 Fast to Slow", 2'b01);
        chk("R8 fast_en low in Slow", {1'b0, fast_en}, 2'b00);

        // R5: Slow to Dual refused while the fast oscillator is not ready
        core_slow = 0; step();
        chk_outs("R5 clear refused", 2'b01);
        core_slow = 1; step();
        chk("R6 Slow holds on rise", mode, 2'b01);

        // R7/R3: accepted exactly at the third edge after the flag rises
        fast_on = 1; fast_st = 1; step();
        step();
        core_slow = 0; step();
        chk_outs("R3 R7 Slow to Dual at third edge", 2'b10);

        // R9: Dual to Slow and back
        core_slow = 1; step();
        chk_outs("R9 Dual to Slow", 2'b01);
        core_slow = 0; step();
        chk_outs("R3 Slow to Dual again", 2'b10);
        split_en = 1; step();
        chk("R6 split rise in Dual ignored", mode, 2'b10);
        split_en = 0; step();
        chk_outs("R9 Dual to Fast by split fall", 2'b00);

        // R10: sweep of simultaneous requests from Fast
        for (int c = 0; c < 4; c++) begin
            do_reset();
            slow_on = 1; fast_on = 1;
            step(); step(); step();
            split_en  = c[0];
            core_slow = c[1];
            step();
            chk_outs("R10 sweep", c[0] ? 2'b10 : (c[1] ? 2'b01 : 2'b00));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule